// File: doc/BRIEF.md
# I2C Bus Start/Stop Condition Sequencer

This block drives the SCL and SDA lines of an I2C master to form START and STOP conditions. Software writes one byte to a status register. The top two bits of that byte pick the communication mode. When both are 1, the bus-busy bit of the same byte selects the sequence: a 1 asks for a START and a 0 asks for a STOP. The lines are open-drain, so each output is a pull-low enable: 1 drives the line low and 0 releases it.

Each sequence has three phases: a setup phase, a hold phase and a flag update. Their lengths are counted in system clock cycles. A standard mode (20/20/12 cycles) and a high-speed mode (10/10/6 cycles) are available, and the mode is captured when the command is accepted. The state machine has four states:
- `ST_IDLE` waits for a command and keeps the lines in their parked state.
- `ST_SETUP` times the setup phase.
- `ST_HOLD` times the hold phase.
- `ST_LAUNCH` drives SCL low after a START and sends a one-cycle pulse to the byte-clock logic, which then loads its bit counter with zero.

The transitions are:
- IDLE→SETUP on an accepted START/STOP command.
- SETUP→HOLD when the setup count expires.
- HOLD→LAUNCH when the hold count expires on a START.
- HOLD→IDLE when the hold count expires on a STOP.
- LAUNCH→IDLE after one cycle.

The flags owned by neighbouring logic are taken in as inputs and shown in the lower five status bits: interrupt-pending, arbitration lost, addressed as slave, general call and last received bit.

Top module: `i2c_cond_gen`

## Requirements
- R1: While `en_i` is 0, a write changes neither the status byte nor SCL/SDA.
- R2: A write of bits[7:5]=111 while idle and enabled starts a START. SCL and SDA stay released for the setup time. SDA is then pulled low for the hold time with SCL still released.
- R3: A write of bits[7:5]=110 while idle and enabled starts a STOP. SDA is pulled low and SCL is released for the setup time. SDA is then released, and both lines stay released through the hold time and afterwards.
- R4: In standard mode (`hs_i`=0 at the write), the counts measured from the write edge are: the SDA change at cycle 20, the end of the hold phase at cycle 40, and the status bit 5 update at cycle 12.
- R5: In high-speed mode (`hs_i`=1 at the write), the same three points fall at cycles 10, 20 and 6.
- R6: When a START's hold phase ends, SCL and SDA are both pulled low and `byte_start_o` pulses for exactly one cycle. Both lines then stay low until a STOP.
- R7: Status bit 7 (master) and bit 6 (transmit) take the written bits 7:6 on every accepted write. The mode encoding is 00 slave receive, 01 slave transmit, 10 master receive and 11 master transmit. Codes other than 11 start no sequence.
- R8: Status bits 4..0 show, one cycle late, the inputs `pin_n_i`, `al_i`, `aas_i`, `gcall_i` and `lrb_i` in that order. Written bits 4..0 are ignored.
- R9: A write that arrives while a sequence is running is ignored. The mode bits are unchanged and the running sequence keeps its timing.
- R10: Status bit 5 (bus busy) never takes the written bit 5. It changes only at the timed update point: it becomes 1 for a START and 0 for a STOP.
- R11: A synchronous active-high `rst` clears bits 7:5, presets bit 4 to 1, clears bits 3..0 and releases both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Interface enable; commands are accepted only when 1 |
| hs_i | input | 1 | Timing mode: 0 standard, 1 high-speed |
| wr_i | input | 1 | Status register write strobe |
| wr_data_i | input | 8 | Status register write data |
| pin_n_i | input | 1 | Interrupt flag from neighbouring logic (0 = pending) |
| al_i | input | 1 | Arbitration-lost flag |
| aas_i | input | 1 | Addressed-as-slave flag |
| gcall_i | input | 1 | General-call flag |
| lrb_i | input | 1 | Last received bit |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| status_o | output | 8 | Status byte {MST, TRX, BB, PIN, AL, AAS, general call, LRB} |
| byte_start_o | output | 1 | One-cycle pulse that starts clocking of one byte |

## Verification
A START from released lines, and a STOP from parked-low lines, are run in both timing modes. Checks at the cycle before and the cycle of every transition separate a correct setup count, hold count and busy-flag delay from a count that is off by one or belongs to the wrong mode. Extra writes arrive during a running sequence, and a write is made with the block disabled. These show that only idle, enabled writes act. Writes of the non-sequence mode codes, of the busy bit alone, and of flag bits set opposite to the flag inputs show which status fields software owns and which it cannot touch.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HOLD,
        ST_LAUNCH
    } cond_state_e;

    localparam int STAT_W = 8;
    localparam int FLAG_W = 5;
endpackage

// File: rtl/i2c_cond_timing.sv
module i2c_cond_timing #(
    parameter int CW        = 6,
    parameter int STD_SETUP = 20,
    parameter int STD_HOLD  = 20,
    parameter int STD_BB    = 12,
    parameter int HS_SETUP  = 10,
    parameter int HS_HOLD   = 10,
    parameter int HS_BB     = 6
) (
    input  logic          hs_i,
    output logic [CW-1:0] setup_o,
    output logic [CW-1:0] hold_o,
    output logic [CW-1:0] bb_o
);
    // Phase lengths picked by the latched timing mode
    always_comb begin
        setup_o = hs_i ? CW'(HS_SETUP) : CW'(STD_SETUP);
        hold_o  = hs_i ? CW'(HS_HOLD)  : CW'(STD_HOLD);
        bb_o    = hs_i ? CW'(HS_BB)    : CW'(STD_BB);
    end
endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
    import i2c_cond_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          wr_i,
    input  logic [2:0]    cmd_i,      // written bits 7:5
    input  logic          hs_i,
    input  logic [CW-1:0] setup_len_i,
    input  logic [CW-1:0] hold_len_i,
    input  logic [CW-1:0] bb_len_i,   // must not exceed setup_len_i
    output logic          hs_lat_o,
    output logic          accept_o,
    output logic          bb_upd_o,
    output logic          bb_val_o,
    output logic          busy_o,
    output logic          scl_oe_o,
    output logic          sda_oe_o,
    output logic          byte_start_o
);
    cond_state_e   state_q;
    logic [CW-1:0] cnt_q;
    logic          is_stop_q;
    logic          park_q;
    logic          go;

    assign accept_o = en_i && wr_i && (state_q == ST_IDLE);
    assign go       = accept_o && (cmd_i[2:1] == 2'b11);
    assign busy_o   = (state_q != ST_IDLE);
    assign hs_lat_o = hs_q;

    logic hs_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            is_stop_q <= 1'b0;
            hs_q      <= 1'b0;
            park_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        state_q   <= ST_SETUP;
                        cnt_q     <= '0;
                        is_stop_q <= !cmd_i[0];
                        hs_q      <= hs_i;
                    end
                end
                ST_SETUP: begin
                    if (cnt_q == setup_len_i - CW'(1)) begin
                        state_q <= ST_HOLD;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                ST_HOLD: begin
                    if (cnt_q == hold_len_i - CW'(1)) begin
                        cnt_q <= '0;
                        if (is_stop_q) begin
                            state_q <= ST_IDLE;
                            park_q  <= 1'b0;
                        end else begin
                            state_q <= ST_LAUNCH;
                        end
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                ST_LAUNCH: begin
                    state_q <= ST_IDLE;
                    park_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        bb_upd_o     = (state_q == ST_SETUP) && (cnt_q == bb_len_i - CW'(1));
        bb_val_o     = !is_stop_q;
        byte_start_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                scl_oe_o = park_q;
                sda_oe_o = park_q;
            end
            ST_SETUP: begin
                scl_oe_o = 1'b0;
                sda_oe_o = is_stop_q;
            end
            ST_HOLD: begin
                scl_oe_o = 1'b0;
                sda_oe_o = !is_stop_q;
            end
            ST_LAUNCH: begin
                scl_oe_o     = 1'b1;
                sda_oe_o     = 1'b1;
                byte_start_o = 1'b1;
            end
            default: begin
                scl_oe_o = 1'b0;
                sda_oe_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/i2c_cond_status.sv
module i2c_cond_status
    import i2c_cond_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic [1:0]        mode_i,
    input  logic              bb_upd_i,
    input  logic              bb_val_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [STAT_W-1:0] status_o
);
    logic [1:0]        mode_q;
    logic              bb_q;
    logic [FLAG_W-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 2'b00;
            bb_q    <= 1'b0;
            flags_q <= FLAG_W'(5'b10000);
        end else begin
            if (accept_i) mode_q <= mode_i;
            if (bb_upd_i) bb_q   <= bb_val_i;
            flags_q <= flags_i;
        end
    end

    assign status_o = {mode_q, bb_q, flags_q};
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int STD_SETUP = 20,
    parameter int STD_HOLD  = 20,
    parameter int STD_BB    = 12,
    parameter int HS_SETUP  = 10,
    parameter int HS_HOLD   = 10,
    parameter int HS_BB     = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       hs_i,
    input  logic       wr_i,
    input  logic [7:0] wr_data_i,
    input  logic       pin_n_i,
    input  logic       al_i,
    input  logic       aas_i,
    input  logic       gcall_i,
    input  logic       lrb_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    output logic [7:0] status_o,
    output logic       byte_start_o
);
    localparam int MAX_A = (STD_SETUP > STD_HOLD) ? STD_SETUP : STD_HOLD;
    localparam int MAX_B = (HS_SETUP > HS_HOLD) ? HS_SETUP : HS_HOLD;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_T + 1);

    logic          hs_lat;
    logic          accept_w;
    logic          bb_upd_w;
    logic          bb_val_w;
    logic          busy_w;
    logic [CW-1:0] setup_len;
    logic [CW-1:0] hold_len;
    logic [CW-1:0] bb_len;
    logic          wr_low_unused;

    assign wr_low_unused = ^wr_data_i[4:0];

    i2c_cond_timing #(
        .CW(CW), .STD_SETUP(STD_SETUP), .STD_HOLD(STD_HOLD), .STD_BB(STD_BB),
        .HS_SETUP(HS_SETUP), .HS_HOLD(HS_HOLD), .HS_BB(HS_BB)
    ) u_timing (
        .hs_i    (hs_lat),
        .setup_o (setup_len),
        .hold_o  (hold_len),
        .bb_o    (bb_len)
    );

    i2c_cond_fsm #(.CW(CW)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en_i),
        .wr_i         (wr_i),
        .cmd_i        (wr_data_i[7:5]),
        .hs_i         (hs_i),
        .setup_len_i  (setup_len),
        .hold_len_i   (hold_len),
        .bb_len_i     (bb_len),
        .hs_lat_o     (hs_lat),
        .accept_o     (accept_w),
        .bb_upd_o     (bb_upd_w),
        .bb_val_o     (bb_val_w),
        .busy_o       (busy_w),
        .scl_oe_o     (scl_oe_o),
        .sda_oe_o     (sda_oe_o),
        .byte_start_o (byte_start_o)
    );

    i2c_cond_status u_status (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept_w),
        .mode_i   (wr_data_i[7:6]),
        .bb_upd_i (bb_upd_w),
        .bb_val_i (bb_val_w),
        .flags_i  ({pin_n_i, al_i, aas_i, gcall_i, lrb_i}),
        .status_o (status_o)
    );
endmodule

// File: rtl/i2c_cond_chk.sv
module i2c_cond_chk (
    input logic       clk,
    input logic       rst,
    input logic       en_i,
    input logic       wr_i,
    input logic       busy,
    input logic       scl_oe_o,
    input logic       sda_oe_o,
    input logic       byte_start_o,
    input logic [7:0] status_o
);
    AST_OFF_WRITE_NO_MODE: assert property (@(posedge clk) disable iff (rst) (!en_i && wr_i) |=> $stable(status_o[7:6])); // R1
    AST_BUSY_WRITE_NO_MODE: assert property (@(posedge clk) disable iff (rst) (busy && wr_i) |=> $stable(status_o[7:6])); // R9
    AST_BB_NOT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst) (en_i && wr_i && !busy) |=> $stable(status_o[5])); // R10
    AST_LAUNCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) byte_start_o |=> !byte_start_o); // R6
    AST_LAUNCH_LINES_LOW: assert property (@(posedge clk) disable iff (rst) byte_start_o |-> (scl_oe_o && sda_oe_o)); // R6
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (status_o[7:5] == 3'b000 && status_o[4] && !scl_oe_o && !sda_oe_o)); // R11
endmodule

bind i2c_cond_gen i2c_cond_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en_i),
    .wr_i         (wr_i),
    .busy         (busy_w),
    .scl_oe_o     (scl_oe_o),
    .sda_oe_o     (sda_oe_o),
    .byte_start_o (byte_start_o),
    .status_o     (status_o)
);

// File: tb/i2c_cond_gen_tb.sv
module i2c_cond_gen_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int          at;
        string       req;
        logic [10:0] exp;   // {byte_start, scl_oe, sda_oe, status}
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_i = 1'b0;
    logic       hs_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       pin_n_i = 1'b1;
    logic       al_i = 1'b0;
    logic       aas_i = 1'b0;
    logic       gcall_i = 1'b0;
    logic       lrb_i = 1'b0;
    logic       scl_oe_o;
    logic       sda_oe_o;
    logic [7:0] status_o;
    logic       byte_start_o;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    item_t sb[$];

    i2c_cond_gen u_dut (
        .clk(clk), .rst(rst), .en_i(en_i), .hs_i(hs_i), .wr_i(wr_i),
        .wr_data_i(wr_data_i), .pin_n_i(pin_n_i), .al_i(al_i), .aas_i(aas_i),
        .gcall_i(gcall_i), .lrb_i(lrb_i), .scl_oe_o(scl_oe_o),
        .sda_oe_o(sda_oe_o), .status_o(status_o), .byte_start_o(byte_start_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expected item whose cycle has come
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                logic [10:0] act;
                act = {byte_start_o, scl_oe_o, sda_oe_o, status_o};
                checks++;
                if (act !== sb[i].exp) begin
                    errors++;
                    $display("FAIL %s cycle %0d: actual=%b expected=%b",
                             sb[i].req, cyc, act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic push(input int at, input string req, input logic bs,
                        input logic scl, input logic sda, input logic [7:0] st);
        item_t it;
        it.at = at; it.req = req; it.exp = {bs, scl, sda, st};
        sb.push_back(it);
    endtask

    task automatic issue(input logic [7:0] d, output int w);
        @(negedge clk);
        wr_i = 1'b1; wr_data_i = d; w = cyc + 1;
        @(negedge clk);
        wr_i = 1'b0; wr_data_i = 8'h00;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int w;
        int w2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        push(cyc + 1, "R11", 0, 0, 0, 8'h10);
        en_i = 1'b1;
        repeat (3) @(negedge clk);

        // Standard START: R2 R4 R10 R6
        hs_i = 1'b0;
        issue(8'hE0, w);
        push(w + 1,  "R10", 0, 0, 0, 8'hD0);
        push(w + 11, "R4",  0, 0, 0, 8'hD0);
        push(w + 12, "R4",  0, 0, 0, 8'hF0);
        push(w + 19, "R2",  0, 0, 0, 8'hF0);
        push(w + 20, "R2",  0, 0, 1, 8'hF0);
        push(w + 39, "R4",  0, 0, 1, 8'hF0);
        push(w + 40, "R6",  1, 1, 1, 8'hF0);
        push(w + 41, "R6",  0, 1, 1, 8'hF0);
        push(w + 44, "R6",  0, 1, 1, 8'hF0);
        repeat (46) @(negedge clk);

        // Standard STOP: R3 R4 R10
        issue(8'hC0, w);
        push(w + 1,  "R3",  0, 0, 1, 8'hF0);
        push(w + 11, "R4",  0, 0, 1, 8'hF0);
        push(w + 12, "R10", 0, 0, 1, 8'hD0);
        push(w + 19, "R3",  0, 0, 1, 8'hD0);
        push(w + 20, "R3",  0, 0, 0, 8'hD0);
        push(w + 42, "R3",  0, 0, 0, 8'hD0);
        repeat (45) @(negedge clk);

        // Disabled write: R1
        en_i = 1'b0;
        issue(8'hE0, w);
        push(w + 1,  "R1", 0, 0, 0, 8'hD0);
        push(w + 13, "R1", 0, 0, 0, 8'hD0);
        push(w + 25, "R1", 0, 0, 0, 8'hD0);
        push(w + 41, "R1", 0, 0, 0, 8'hD0);
        repeat (44) @(negedge clk);
        en_i = 1'b1;

        // High-speed START with writes during the sequence: R5 R9
        hs_i = 1'b1;
        issue(8'hE0, w);
        hs_i = 1'b0;
        push(w + 5,  "R5", 0, 0, 0, 8'hD0);
        push(w + 6,  "R5", 0, 0, 0, 8'hF0);
        push(w + 9,  "R5", 0, 0, 0, 8'hF0);
        push(w + 10, "R5", 0, 0, 1, 8'hF0);
        push(w + 19, "R9", 0, 0, 1, 8'hF0);
        push(w + 20, "R5", 1, 1, 1, 8'hF0);
        push(w + 21, "R6", 0, 1, 1, 8'hF0);
        issue(8'hC0, w2);
        issue(8'h00, w2);
        push(w2 + 1, "R9", 0, 0, 0, 8'hD0);
        repeat (25) @(negedge clk);

        // High-speed STOP: R5
        hs_i = 1'b1;
        issue(8'hC0, w);
        hs_i = 1'b0;
        push(w + 5,  "R5", 0, 0, 1, 8'hF0);
        push(w + 6,  "R5", 0, 0, 1, 8'hD0);
        push(w + 9,  "R5", 0, 0, 1, 8'hD0);
        push(w + 10, "R5", 0, 0, 0, 8'hD0);
        repeat (24) @(negedge clk);

        // Mode codes without a sequence: R7
        issue(8'h80, w);
        push(w + 1,  "R7", 0, 0, 0, 8'h90);
        push(w + 25, "R7", 0, 0, 0, 8'h90);
        repeat (27) @(negedge clk);
        issue(8'h40, w);
        push(w + 1, "R7", 0, 0, 0, 8'h50);
        repeat (2) @(negedge clk);

        // Busy bit alone cannot be written: R10
        issue(8'h20, w);
        push(w + 1,  "R10", 0, 0, 0, 8'h10);
        push(w + 15, "R10", 0, 0, 0, 8'h10);
        repeat (17) @(negedge clk);

        // Flag inputs shown, written low bits ignored: R8
        @(negedge clk);
        pin_n_i = 1'b0; al_i = 1'b1; aas_i = 1'b0; gcall_i = 1'b1; lrb_i = 1'b1;
        issue(8'h54, w);
        push(w + 1, "R8", 0, 0, 0, 8'h4B);
        @(negedge clk);
        pin_n_i = 1'b1; al_i = 1'b0; gcall_i = 1'b0; lrb_i = 1'b0;
        push(cyc + 2, "R8", 0, 0, 0, 8'h50);
        repeat (5) @(negedge clk);

        if (sb.size() != 0) begin
            errors += sb.size();
            checks += sb.size();
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
        end
        finish_run();
    end
endmodule